// File: doc/BRIEF.md
# Interleaved Dual-Channel Converter Input Register

This block is the digital front end of a two-channel digital-to-analog converter whose channels share a single 8-bit data bus. The words for the two channels alternate on that bus within each clock period. The second-channel word is on the bus ahead of the clock's falling edge. The first-channel word follows it and is on the bus ahead of the next rising edge.

On a falling edge, the block copies the bus into a holding register for channel 2 and leaves the outputs alone. On the next rising edge, it captures the bus as the channel-1 code and transfers the held word to the channel-2 code in the same instant. The two analog channels therefore change together, even though their data arrived half a clock period apart. An active-low select qualifies every capture. A one-cycle strobe marks each rising edge that updated the outputs.

Top module: `pairdac_front`

## Requirements
- R1: A synchronous active-high reset, held across both a falling and a rising clock edge, clears the channel-2 holding register, both output codes and the update strobe to zero.
- R2: On a falling clock edge with `sel_n` low, the 8-bit bus value (bit 7 most significant, bit 0 least significant) is stored in the channel-2 holding register without altering either output code.
- R3: On a rising clock edge with `sel_n` low, `code_a` takes the bus value and `code_b` takes the content of the holding register, both at that same edge.
- R4: Neither output code changes on a falling clock edge, whatever the select and bus values.
- R5: A falling edge with `sel_n` high leaves the holding register unchanged; this is observed as the earlier held word reaching `code_b` at the next selected rising edge.
- R6: A rising edge with `sel_n` high leaves both output codes unchanged.
- R7: `upd` is high for exactly the one cycle following each rising edge sampled with `sel_n` low, and low otherwise.
- R8: With select low on every edge, a stream of pairs (channel-2 word first, then channel-1 word) presented back to back appears pair by pair on both outputs at one rising edge per clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; falling edge preloads channel 2, rising edge updates both outputs |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Active-low select qualifying captures on both edges |
| din | input | 8 | Shared interleaved data bus |
| code_a | output | 8 | Registered channel-1 code |
| code_b | output | 8 | Registered channel-2 code |
| upd | output | 1 | One-cycle pulse after each selected rising edge |

## Verification
On every cycle, the assertions check that a selected rising edge moves the bus into `code_a` and the held word into `code_b`. They also check that a deselected edge of either polarity freezes the registers it would have loaded, that the strobe follows the select sampled at the rising edge, and that reset zeroes everything. Other properties can only be shown by the bench's scenarios. These are: that outputs stay put across falling edges, as seen at the pins half a cycle later; that a word preloaded before a deselected falling edge survives until the next selected update; and that long runs of random pairs, with select toggled independently at each edge, land as matched pairs.

// File: rtl/pairdac_pkg.sv
package pairdac_pkg;

    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] dac_word_t;

    typedef struct packed {
        dac_word_t a;
        dac_word_t b;
    } code_pair_t;

    localparam code_pair_t PAIR_ZERO = '{a: '0, b: '0};

    function automatic logic selected(input logic sel_n);
        return ~sel_n;
    endfunction

endpackage

// File: rtl/pairdac_hold.sv
module pairdac_hold
    import pairdac_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_n,
    input  dac_word_t din,
    output dac_word_t held
);

    dac_word_t held_q;

    always_ff @(negedge clk) begin
        if (rst)
            held_q <= '0;
        else if (selected(sel_n))
            held_q <= din;
    end

    assign held = held_q;

    assert_hold_capture_R2: assert property (@(negedge clk) disable iff (rst)
        !sel_n |=> held == $past(din));

    assert_hold_frozen_R5: assert property (@(negedge clk) disable iff (rst)
        sel_n |=> $stable(held));

    assert_hold_reset_R1: assert property (@(negedge clk)
        rst |=> held == '0);

endmodule

// File: rtl/pairdac_out.sv
module pairdac_out
    import pairdac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_n,
    input  dac_word_t  din,
    input  dac_word_t  held,
    output code_pair_t codes,
    output logic       upd
);

    code_pair_t codes_q;
    logic       upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            codes_q <= PAIR_ZERO;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= selected(sel_n);
            if (selected(sel_n)) begin
                codes_q.a <= din;
                codes_q.b <= held;
            end
        end
    end

    assign codes = codes_q;
    assign upd   = upd_q;

    assert_joint_load_R3: assert property (@(posedge clk) disable iff (rst)
        !sel_n |=> (codes.a == $past(din)) && (codes.b == $past(held)));

    assert_codes_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> $stable(codes));

    assert_strobe_on_R7: assert property (@(posedge clk) disable iff (rst)
        !sel_n |=> upd);

    assert_strobe_off_R7: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> !upd);

    assert_out_reset_R1: assert property (@(posedge clk)
        rst |=> (codes == PAIR_ZERO) && !upd);

endmodule

// File: rtl/pairdac_front.sv
module pairdac_front
    import pairdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              upd
);

    dac_word_t  held_w;
    code_pair_t codes_w;

    pairdac_hold u_hold (
        .clk   (clk),
        .rst   (rst),
        .sel_n (sel_n),
        .din   (din),
        .held  (held_w)
    );

    pairdac_out u_out (
        .clk   (clk),
        .rst   (rst),
        .sel_n (sel_n),
        .din   (din),
        .held  (held_w),
        .codes (codes_w),
        .upd   (upd)
    );

    assign code_a = codes_w.a;
    assign code_b = codes_w.b;

endmodule

// File: tb/pairdac_front_test.sv
module pairdac_front_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] code_a, code_b;
    logic       upd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_hold = 8'h00;
    logic [7:0] m_a = 8'h00;
    logic [7:0] m_b = 8'h00;
    logic       m_upd = 1'b0;

    always #10 clk = ~clk;

    pairdac_front uut (
        .clk    (clk),
        .rst    (rst),
        .sel_n  (sel_n),
        .din    (din),
        .code_a (code_a),
        .code_b (code_b),
        .upd    (upd)
    );

    function automatic logic [7:0] next_a(input logic sel, input logic [7:0] bus,
                                          input logic [7:0] cur);
        return sel ? cur : bus;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Entered at posedge+2. Drives one full period: ch2 word toward the falling
    // edge, ch1 word toward the rising edge; selects given per edge.
    task automatic run_pair(input logic s_f, input logic [7:0] w2,
                            input logic s_r, input logic [7:0] w1, input string req);
        sel_n = s_f;
        din   = w2;
        @(negedge clk);
        #1;
        if (!s_f) m_hold = w2;
        check({"R4 code_a across falling edge ", req}, code_a, m_a);
        check({"R4 code_b across falling edge ", req}, code_b, m_b);
        #1;
        sel_n = s_r;
        din   = w1;
        @(posedge clk);
        #1;
        m_a   = next_a(s_r, w1, m_a);
        if (!s_r) m_b = m_hold;
        m_upd = !s_r;
        check({"code_a ", req}, code_a, m_a);
        check({"code_b ", req}, code_b, m_b);
        check({"R7 upd ", req}, {7'd0, upd}, {7'd0, m_upd});
        #1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset held across several edges with select low and busy bus
        rst = 1'b1;
        sel_n = 1'b0;
        din = 8'hA5;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        check("R1 code_a after reset", code_a, 8'h00);
        check("R1 code_b after reset", code_b, 8'h00);
        check("R1 upd after reset", {7'd0, upd}, 8'h00);
        // R1: holding register cleared, seen via code_b without a new preload
        run_pair(1'b1, 8'h77, 1'b0, 8'h3C, "R1 held cleared");

        // R2/R3: basic pair, MSB and LSB distinct
        run_pair(1'b0, 8'h81, 1'b0, 8'h7E, "R3 basic pair");
        run_pair(1'b0, 8'hFF, 1'b0, 8'h00, "R2 R3 extremes");
        run_pair(1'b0, 8'h00, 1'b0, 8'hFF, "R2 R3 extremes swapped");

        // R6: preload occurs but rising edge deselected
        run_pair(1'b0, 8'h5A, 1'b1, 8'hC3, "R6 rising deselected");
        // R5: falling deselected, earlier preload 5A must reach code_b
        run_pair(1'b1, 8'h12, 1'b0, 8'h34, "R5 hold kept");
        check("R5 code_b carries kept word", code_b, 8'h5A);

        // R6: both edges deselected, nothing moves
        run_pair(1'b1, 8'hEE, 1'b1, 8'hDD, "R6 idle");
        check("R6 code_a idle", code_a, 8'h34);

        // R8: back-to-back pairs
        for (int i = 0; i < 16; i++) begin
            logic [7:0] w2 = 8'(i * 17 + 3);
            logic [7:0] w1 = 8'(255 - i * 13);
            run_pair(1'b0, w2, 1'b0, w1, "R8 stream");
            check("R8 pair b", code_b, w2);
            check("R8 pair a", code_a, w1);
        end

        // Random: select independent per edge
        for (int i = 0; i < 400; i++) begin
            logic sf = ($urandom % 4) == 0;
            logic sr = ($urandom % 4) == 0;
            run_pair(sf, 8'($urandom), sr, 8'($urandom), "R2 R3 R5 R6 random");
        end

        // R1: reset mid-stream after data was loaded
        rst = 1'b1;
        sel_n = 1'b0;
        din = 8'h99;
        repeat (2) @(posedge clk);
        #2;
        rst = 1'b0;
        m_a = 8'h00; m_b = 8'h00; m_hold = 8'h00; m_upd = 1'b0;
        check("R1 code_a mid reset", code_a, 8'h00);
        check("R1 code_b mid reset", code_b, 8'h00);
        run_pair(1'b1, 8'h44, 1'b0, 8'h55, "R1 held cleared again");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule